// File: doc/BRIEF.md
# Video Clamp Window Generator

This block produces the per-line clamp timing for a three-channel video digitizer. It runs on the pixel clock. It drives two enables: `clamp_en` gates the analog clamp switch and `loop_en` gates the black-level offset loop. The clamp circuit and the integrator are outside this block.

The pulse has one of two sources. In the internal mode, a programmable window opens a set number of pixel clocks after each horizontal sync trailing edge. In the external mode, a registered copy of a dedicated clamp pin is used. In either mode the pulse can be split: the first part drives only the analog clamp and the remainder drives only the black loop. Clamp pulses can also be suppressed for a programmable number of lines on each side of vertical sync. This keeps equalizing pulses from disturbing the black level.

Top module: `clamp_window_gen`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `clamp_en` and `loop_en` are low. Reset also clears the line counter and the recorded field length.
- R2: `hs_pol`=1 makes `hsync` active high and `hs_pol`=0 makes it active low. The trailing edge is the change from the active level to the inactive level.
- R3: In internal mode (`src_ext`=0) with `split`=0, both enables go high after the (PLACE+4)-th rising clock edge following the first edge that samples the trailing level of `hsync`. They stay high for DURATION clocks.
- R4: With DURATION=0, no enable is raised on that line.
- R5: A trailing edge that arrives while the window is still counting restarts the count from that edge, and only one window results.
- R6: With a nonzero `split` m (m < DURATION), `clamp_en` is high for the first m clocks of the window and `loop_en` is high for the remaining DURATION−m clocks. The two are never high together.
- R7: In external mode (`src_ext`=1), `clamp_pin` is registered once. `clp_pol`=0 makes the pin active high and `clp_pol`=1 makes it active low. A pin level sampled at clock edge k appears on the enables after edge k+1.
- R8: In external mode `hsync` has no effect on the enables. In internal mode `clamp_pin` has no effect on them.
- R9: In external mode the split counts from the first clock of the registered pin pulse. `clamp_en` covers the first m clocks and `loop_en` covers the rest of the pulse.
- R10: `vsync` is active high. Lines are counted by `hsync` leading edges after each `vsync` rising edge. At each such edge the count of the field just ended is recorded. Once a count is recorded, line j is suppressed when j + PRE exceeds that count. PRE=0 disables this suppression.
- R11: After each `vsync` rising edge, lines 1 to POST (numbered by `hsync` leading edges) are suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Horizontal sync, asynchronous |
| vsync | input | 1 | Vertical sync, active high, asynchronous |
| clamp_pin | input | 1 | External clamp pulse |
| src_ext | input | 1 | 0: internal window, 1: external pin |
| hs_pol | input | 1 | 1: hsync active high, 0: active low |
| clp_pol | input | 1 | 0: pin active high, 1: active low |
| place | input | 8 | Window delay after hsync trailing edge, clocks |
| duration | input | 8 | Window length, clocks |
| split | input | 8 | Clamp-only clocks at window start (0: no split) |
| pre_lines | input | 8 | Lines suppressed before vsync |
| post_lines | input | 8 | Lines suppressed after vsync |
| clamp_en | output | 1 | Analog clamp enable |
| loop_en | output | 1 | Black-level loop enable |

## Verification
The hardest case to reach is line suppression. Pre-sync suppression depends on the length of the field that came before, so a lone VSYNC pulse shows nothing. The stimulus first resets the block to clear any line count left by earlier tests. It then drives four fields of fixed-length lines separated by VSYNC pulses and counts the clamp clocks on every line. Each count is compared with a per-line expectation built from the field index, the line index, PRE and POST.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

    localparam int FIELD_W = 8;

    typedef logic [FIELD_W-1:0] field_t;

    // Window state handed from a source to the phase splitter
    typedef struct packed {
        logic   active;
        field_t offset;   // clocks since the window opened
    } win_t;

    typedef struct packed {
        logic clamp;
        logic loop;
    } phase_t;

    // Divide an open window into clamp-only and loop-only parts
    function automatic phase_t split_phase(win_t w, field_t m);
        phase_t p;
        p.clamp = 1'b0;
        p.loop  = 1'b0;
        if (w.active) begin
            if (m == '0) begin
                p.clamp = 1'b1;
                p.loop  = 1'b1;
            end else if (w.offset < m) begin
                p.clamp = 1'b1;
            end else begin
                p.loop = 1'b1;
            end
        end
        return p;
    endfunction

    // Map a pin to its internal active-high meaning
    function automatic logic to_active(logic pin, logic invert);
        return pin ^ invert;
    endfunction

endpackage

// File: rtl/cwg_sync_edge.sv
module cwg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic lvl_d
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) lvl_d <= 1'b0;
        else     lvl_d <= chain[STAGES-1];
    end

    assign lvl = chain[STAGES-1];

endmodule

// File: rtl/cwg_window_timer.sv
module cwg_window_timer
    import cwg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   trail,
    input  field_t place,
    input  field_t dur,
    output win_t   win
);

    localparam int CNT_W = FIELD_W + 1;

    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] stop_at;
    logic [CNT_W-1:0] start_at;
    logic             running;

    assign start_at = {1'b0, place};
    assign stop_at  = {1'b0, place} + {1'b0, dur};

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed <= '0;
            running <= 1'b0;
        end else if (trail) begin
            elapsed <= '0;           // restart on every trailing edge
            running <= 1'b1;
        end else if (running) begin
            if (elapsed >= stop_at) running <= 1'b0;
            else                    elapsed <= elapsed + 1'b1;
        end
    end

    logic [CNT_W-1:0] rel;
    assign rel = elapsed - start_at;

    always_comb begin
        win.active = running && (elapsed >= start_at) && (elapsed < stop_at);
        win.offset = rel[FIELD_W-1:0];
    end

    AST_TRAIL_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        trail |=> running && elapsed == '0) else $error("restart lost"); // R5

endmodule

// File: rtl/cwg_coast_ctrl.sv
module cwg_coast_ctrl
    import cwg_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   hs_lead,
    input  logic   vs_rise,
    input  field_t pre_lines,
    input  field_t post_lines,
    output logic   coast
);

    localparam int SUM_W = ((LINE_W > FIELD_W) ? LINE_W : FIELD_W) + 1;
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] field_len;
    logic              field_ok;
    field_t            post_left;
    logic              post_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt  <= '0;
            field_len <= '0;
            field_ok  <= 1'b0;
            post_left <= '0;
            post_act  <= 1'b0;
        end else if (vs_rise) begin
            field_len <= line_cnt;
            field_ok  <= 1'b1;
            line_cnt  <= '0;
            post_left <= post_lines;
            post_act  <= 1'b0;
        end else if (hs_lead) begin
            if (line_cnt != LINE_MAX) line_cnt <= line_cnt + 1'b1;
            post_act <= (post_left != '0);
            if (post_left != '0) post_left <= post_left - 1'b1;
        end
    end

    logic [SUM_W-1:0] reach;
    logic             pre_act;

    assign reach   = SUM_W'(line_cnt) + SUM_W'(pre_lines);
    assign pre_act = field_ok && (pre_lines != '0) && (reach > SUM_W'(field_len));
    assign coast   = post_act | pre_act;

    AST_POST_LINE_COAST: assert property (@(posedge clk) disable iff (rst)
        (hs_lead && !vs_rise && post_left != '0) |=> coast) else $error("post coast missed"); // R11

endmodule

// File: rtl/clamp_window_gen.sv
module clamp_window_gen
    import cwg_pkg::*;
#(
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync,
    input  logic       vsync,
    input  logic       clamp_pin,
    input  logic       src_ext,
    input  logic       hs_pol,
    input  logic       clp_pol,
    input  logic [7:0] place,
    input  logic [7:0] duration,
    input  logic [7:0] split,
    input  logic [7:0] pre_lines,
    input  logic [7:0] post_lines,
    output logic       clamp_en,
    output logic       loop_en
);

    localparam field_t OFS_MAX = '1;

    // Horizontal sync: polarity, synchronizer, edges
    logic hs_act, hs_lvl, hs_lvl_d, hs_lead, hs_trail;
    assign hs_act = to_active(hsync, ~hs_pol);

    cwg_sync_edge #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (hs_act),
        .lvl   (hs_lvl),
        .lvl_d (hs_lvl_d)
    );

    assign hs_lead  =  hs_lvl & ~hs_lvl_d;
    assign hs_trail = ~hs_lvl &  hs_lvl_d;

    // Vertical sync
    logic vs_lvl, vs_lvl_d, vs_rise;

    cwg_sync_edge #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk   (clk),
        .rst   (rst),
        .din   (vsync),
        .lvl   (vs_lvl),
        .lvl_d (vs_lvl_d)
    );

    assign vs_rise = vs_lvl & ~vs_lvl_d;

    // Internal window source
    win_t int_win;

    cwg_window_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .trail (hs_trail),
        .place (place),
        .dur   (duration),
        .win   (int_win)
    );

    // External pin source: one register, then a run counter
    logic   ext_act;
    field_t ext_ofs;

    always_ff @(posedge clk) begin
        if (rst) ext_act <= 1'b0;
        else     ext_act <= to_active(clamp_pin, clp_pol);
    end

    always_ff @(posedge clk) begin
        if (rst || !ext_act)       ext_ofs <= '0;
        else if (ext_ofs != OFS_MAX) ext_ofs <= ext_ofs + 1'b1;
    end

    win_t ext_win;
    assign ext_win.active = ext_act;
    assign ext_win.offset = ext_ofs;

    // Line suppression around vertical sync
    logic coast;

    cwg_coast_ctrl #(.LINE_W(LINE_W)) u_coast (
        .clk        (clk),
        .rst        (rst),
        .hs_lead    (hs_lead),
        .vs_rise    (vs_rise),
        .pre_lines  (pre_lines),
        .post_lines (post_lines),
        .coast      (coast)
    );

    // Source select, split, output register
    win_t   sel_win;
    phase_t ph;

    assign sel_win = src_ext ? ext_win : int_win;
    assign ph      = split_phase(sel_win, split);

    always_ff @(posedge clk) begin
        if (rst) begin
            clamp_en <= 1'b0;
            loop_en  <= 1'b0;
        end else begin
            clamp_en <= ph.clamp & ~coast;
            loop_en  <= ph.loop  & ~coast;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !clamp_en && !loop_en) else $error("active after reset"); // R1
    AST_SPLIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        ($past(split) != '0) |-> !(clamp_en && loop_en)) else $error("split overlap"); // R6
    AST_ZERO_DUR_SILENT: assert property (@(posedge clk) disable iff (rst)
        (!$past(src_ext) && $past(duration) == '0) |-> !clamp_en && !loop_en) else $error("zero length pulse"); // R4
    AST_COAST_GATES: assert property (@(posedge clk) disable iff (rst)
        $past(coast) |-> !clamp_en && !loop_en) else $error("coasted line clamped"); // R10
    AST_EXT_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (rst)
        ($past(src_ext) && !$past(ext_act)) |-> !clamp_en && !loop_en) else $error("pulse without pin"); // R7

endmodule

// File: tb/clamp_window_gen_bench.sv
`timescale 1ns/1ps
module clamp_window_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0, vsync = 1'b0, clamp_pin = 1'b0;
    logic       src_ext = 1'b0, hs_pol = 1'b1, clp_pol = 1'b0;
    logic [7:0] place = 8'd0, duration = 8'd0, split = 8'd0;
    logic [7:0] pre_lines = 8'd0, post_lines = 8'd0;
    logic       clamp_en, loop_en;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clamp_window_gen u_clamp_window_gen (
        .clk(clk), .rst(rst), .hsync(hsync), .vsync(vsync), .clamp_pin(clamp_pin),
        .src_ext(src_ext), .hs_pol(hs_pol), .clp_pol(clp_pol),
        .place(place), .duration(duration), .split(split),
        .pre_lines(pre_lines), .post_lines(post_lines),
        .clamp_en(clamp_en), .loop_en(loop_en)
    );

    // {hs_pol, place, duration, split}
    localparam logic [24:0] VEC [0:5] = '{
        {1'b1, 8'd0,   8'd1,  8'd0},
        {1'b0, 8'd3,   8'd6,  8'd0},
        {1'b1, 8'd10,  8'd8,  8'd3},
        {1'b0, 8'd5,   8'd0,  8'd0},
        {1'b1, 8'd2,   8'd5,  8'd4},
        {1'b0, 8'd200, 8'd20, 8'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Sample n negedges; report first high cycle (0 if none) and counts
    task automatic observe(input int n, output int cs, output int cc,
                           output int ls, output int lc);
        cs = 0; cc = 0; ls = 0; lc = 0;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            if (clamp_en) begin cc++; if (cs == 0) cs = c; end
            if (loop_en)  begin lc++; if (ls == 0) ls = c; end
        end
    endtask

    // One video line of 30 clocks, optional vsync pulse near its end
    task automatic run_line(input bit vs_end, output int cnt, output int lcnt);
        cnt = 0; lcnt = 0;
        for (int c = 0; c < 30; c++) begin
            if (c == 0) hsync = 1'b1;
            if (c == 3) hsync = 1'b0;
            if (vs_end && c == 20) vsync = 1'b1;
            if (vs_end && c == 25) vsync = 1'b0;
            @(negedge clk);
            if (clamp_en) cnt++;
            if (loop_en)  lcnt++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cs, cc, ls, lc;
        int p, d, m, ecc, elc;
        bit pol;

        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 clamp_en in reset", clamp_en, 0);
        check("R1 loop_en in reset", loop_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 clamp_en after reset", clamp_en, 0);
        check("R1 loop_en after reset", loop_en, 0);

        // R2 R3 R4 R6: table walk, internal mode
        for (int i = 0; i < 6; i++) begin
            {pol, p, d, m} = {VEC[i][24], 24'(VEC[i][23:0])} ;
            pol = VEC[i][24];
            p = VEC[i][23:16];
            d = VEC[i][15:8];
            m = VEC[i][7:0];
            @(negedge clk);
            hs_pol = pol; hsync = ~pol;
            place = 8'(p); duration = 8'(d); split = 8'(m);
            repeat (10) @(negedge clk);
            hsync = pol;
            repeat (3) @(negedge clk);
            hsync = ~pol;
            observe(300, cs, cc, ls, lc);
            ecc = (m == 0) ? d : m;
            elc = (m == 0) ? d : d - m;
            check($sformatf("R3 R2 vec%0d clamp count", i), cc, ecc);
            check($sformatf("R6 vec%0d loop count", i), lc, elc);
            if (d == 0) begin
                check($sformatf("R4 vec%0d no clamp", i), cs, 0);
            end else begin
                check($sformatf("R3 vec%0d clamp start", i), cs, p + 4);
                check($sformatf("R6 vec%0d loop start", i), ls, p + 4 + m);
            end
        end

        // R5: second trailing edge restarts the count
        @(negedge clk);
        hs_pol = 1'b1; hsync = 1'b0;
        place = 8'd20; duration = 8'd4; split = 8'd0;
        repeat (10) @(negedge clk);
        hsync = 1'b1; repeat (2) @(negedge clk);
        hsync = 1'b0; repeat (6) @(negedge clk);
        hsync = 1'b1; repeat (2) @(negedge clk);
        hsync = 1'b0;
        observe(60, cs, cc, ls, lc);
        check("R5 restart start", cs, 24);
        check("R5 single window", cc, 4);

        // R8: internal mode ignores the clamp pin
        clamp_pin = 1'b1;
        observe(10, cs, cc, ls, lc);
        clamp_pin = 1'b0;
        observe(10, cs, ecc, ls, elc);
        check("R8 pin ignored internal", cc + ecc, 0);

        // R7: external, active high, no split
        src_ext = 1'b1; clp_pol = 1'b0; split = 8'd0;
        repeat (4) @(negedge clk);
        clamp_pin = 1'b1;
        for (int c = 1; c <= 30; c++) begin
            if (c == 1) ; // pin already active
        end
        cs = 0; cc = 0; ls = 0; lc = 0;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (c == 6) clamp_pin = 1'b0;
            if (clamp_en) begin cc++; if (cs == 0) cs = c; end
            if (loop_en)  lc++;
        end
        check("R7 ext start", cs, 2);
        check("R7 ext length", cc, 6);
        check("R7 ext loop length", lc, 6);

        // R7 R9: external, active low, split 2
        @(negedge clk);
        clp_pol = 1'b1; clamp_pin = 1'b1; split = 8'd2;
        repeat (4) @(negedge clk);
        clamp_pin = 1'b0;
        cs = 0; cc = 0; ls = 0; lc = 0;
        for (int c = 1; c <= 30; c++) begin
            @(negedge clk);
            if (c == 6) clamp_pin = 1'b1;
            if (clamp_en) begin cc++; if (cs == 0) cs = c; end
            if (loop_en)  begin lc++; if (ls == 0) ls = c; end
        end
        check("R9 ext clamp start", cs, 2);
        check("R9 ext clamp length", cc, 2);
        check("R9 ext loop start", ls, 4);
        check("R9 ext loop length", lc, 4);

        // R8: external mode ignores hsync
        place = 8'd1; duration = 8'd5; split = 8'd0;
        hsync = 1'b1; repeat (3) @(negedge clk);
        hsync = 1'b0;
        observe(40, cs, cc, ls, lc);
        check("R8 hsync ignored external", cc + lc, 0);

        // R10 R11: line suppression over four fields
        @(negedge clk);
        src_ext = 1'b0; hs_pol = 1'b1; hsync = 1'b0; vsync = 1'b0;
        place = 8'd2; duration = 8'd5; split = 8'd0;
        pre_lines = 8'd2; post_lines = 8'd1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        for (int f = 0; f < 4; f++) begin
            for (int j = 1; j <= ((f == 3) ? 3 : 8); j++) begin
                bit coasted;
                run_line((f < 3) && (j == 8), cc, lc);
                coasted = (f > 0) && ((j <= 1) || (j + 2 > 8));
                if (f > 0 && j <= 1)
                    check($sformatf("R11 field%0d line%0d", f, j), cc, coasted ? 0 : 5);
                else
                    check($sformatf("R10 field%0d line%0d", f, j), cc, coasted ? 0 : 5);
                if (j == 4) check($sformatf("R10 field%0d line%0d loop", f, j), lc, 5);
            end
        end

        finish_run();
    end

endmodule